// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block picks the message object that should keep an incoming CAN frame. A receiver that has already checked the bits and the CRC presents the identifier, its format (11-bit standard or 29-bit extended) and a one-cycle frame-valid strobe. The filter holds two global masks, one per identifier format. It also holds an identifier, a format bit, a direction bit and a valid bit for each of 15 message objects, and a local mask for the last object. One clock later it reports whether a frame was accepted, which object took it and, for the last object, which of its two buffer slots was written.

Matching takes place in two stages. Objects 1 to 14 are compared under the global mask for the frame's format. Only when none of them accept the frame is object 15 tried, and that object works under the global and the local mask together. Object 15 only receives and has two buffer slots, so the host can read one frame while the next one arrives. Every object has a new-data flag that a store sets and a host release clears. It also has an overrun flag that marks a store into an object the host has not yet emptied.

Top module: `can_af_top`

## Requirements
- R1: A mask bit of 1 forces the identifier bit at that position to be equal, and a mask bit of 0 makes it a don't-care. Standard frames (rx_ext=0) compare rx_id[10:0] under the standard global mask, and the upper rx_id bits are ignored. Extended frames (rx_ext=1) compare rx_id[28:0] under the extended global mask.
- R2: An object is a candidate only when its valid bit is 1 and its format bit equals rx_ext. An object among 1..14 must also have direction bit 0 (receive); direction 1 means transmit and excludes the object.
- R3: When several of objects 1..14 accept a frame, the lowest-numbered one wins.
- R4: Object 15 is tried only if no object among 1..14 accepts the frame. A bit takes part in its comparison only where both the global mask and its local mask hold a 1.
- R5: Object 15 always receives: a direction bit written for it has no effect.
- R6: A frame strobed at clock edge t produces hit=1 and hit_idx (1..15) after edge t+1. Both last one cycle, and hit_idx is 0 whenever hit is 0.
- R7: A store into object k sets new_data bit k-1. A release (ack_we with ack_idx=k, k in 1..14) clears new_data and overrun bits k-1.
- R8: A store into an object among 1..14 whose new_data bit is already set sets that object's overrun bit.
- R9: Object 15 fills slots 0 and 1 alternately and reports the written slot on hit_slot; hit_slot is 0 for other objects. new_data bit 14 stays set while either slot holds an unread frame. A release of object 15 frees the oldest slot, and last_rd_slot names the slot to read next.
- R10: A store into object 15 while both slots are full overwrites the newer slot (reported on hit_slot) and sets overrun bit 14. A release of object 15 clears overrun bit 14.
- R11: Configuration writes use cfg_kind 0 for the standard mask (cfg_id[10:0]), 1 for the extended mask, 2 for object 15's local mask and 3 for the object entry selected by cfg_obj (1..15). A write applies to every frame strobed on a later cycle.
- R12: After reset, hit, hit_idx, new_data and overrun are 0, every object is invalid and all masks are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 std mask, 1 ext mask, 2 local mask, 3 object |
| cfg_obj | input | 4 | Object number 1..15 for object writes |
| cfg_id | input | 29 | Identifier or mask value |
| cfg_ext | input | 1 | Object format, 1 = extended |
| cfg_tx | input | 1 | Object direction, 1 = transmit |
| cfg_valid | input | 1 | Object valid bit |
| rx_valid | input | 1 | Frame-valid strobe |
| rx_ext | input | 1 | Frame format, 1 = extended |
| rx_id | input | 29 | Received identifier |
| ack_we | input | 1 | Host release strobe |
| ack_idx | input | 4 | Object being released |
| hit | output | 1 | Frame accepted (registered) |
| hit_idx | output | 4 | Winning object number, 0 when none |
| hit_slot | output | 1 | Object 15 slot written |
| last_rd_slot | output | 1 | Object 15 slot holding the oldest frame |
| new_data | output | 15 | Per-object new-data flags, bit k-1 = object k |
| overrun | output | 15 | Per-object overrun flags, bit k-1 = object k |

## Verification
The assertions check on every cycle that the result pulse follows a strobe and carries an index in range, that a store always leaves the winner's new-data flag set, and that an overrun flag only rises on a store into an object that already held data and never stands without new data. They also check that object 15 wins only when the low stage had no candidate, and that only object 15 reports a slot. Mask semantics, lowest-number priority, format and direction exclusion, the ignored direction of object 15, and the slot order and overwrite of its buffer depend on the stored configuration. Only the bench's sweeps over whole identifier ranges, compared with its own model, can show these.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;

  typedef enum logic [1:0] {
    CFG_GMASK_STD  = 2'd0,
    CFG_GMASK_EXT  = 2'd1,
    CFG_LMASK_LAST = 2'd2,
    CFG_OBJ        = 2'd3
  } cfg_kind_e;

  typedef struct packed {
    logic            valid;
    logic            ext;
    logic            tx;
    logic [ID_W-1:0] id;
  } obj_entry_t;

  // Bits that exist in a frame of the given format.
  function automatic logic [ID_W-1:0] fmt_span(input logic ext);
    fmt_span = ext ? {ID_W{1'b1}} : {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};
  endfunction

  // Equal on every position that is both cared for and present.
  function automatic logic id_match(input logic [ID_W-1:0] rx,
                                    input logic [ID_W-1:0] obj_id,
                                    input logic [ID_W-1:0] care,
                                    input logic            ext);
    id_match = (((rx ^ obj_id) & care & fmt_span(ext)) == '0);
  endfunction
endpackage

// File: rtl/can_af_cfg.sv
module can_af_cfg
  import can_af_pkg::*;
#(
  parameter  int NOBJ  = 15,
  localparam int IDX_W = $clog2(NOBJ + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_kind,
  input  logic [IDX_W-1:0]      cfg_obj,
  input  logic [ID_W-1:0]       cfg_id,
  input  logic                  cfg_ext,
  input  logic                  cfg_tx,
  input  logic                  cfg_valid,
  output logic [STD_W-1:0]      gmask_std,
  output logic [ID_W-1:0]       gmask_ext,
  output logic [ID_W-1:0]       lmask_last,
  output obj_entry_t [NOBJ-1:0] objs
);
  cfg_kind_e kind;
  assign kind = cfg_kind_e'(cfg_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask_std  <= '1;
      gmask_ext  <= '1;
      lmask_last <= '1;
    end else if (cfg_we) begin
      case (kind)
        CFG_GMASK_STD:  gmask_std  <= cfg_id[STD_W-1:0];
        CFG_GMASK_EXT:  gmask_ext  <= cfg_id;
        CFG_LMASK_LAST: lmask_last <= cfg_id;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NOBJ; k++) begin : g_obj
    obj_entry_t r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (cfg_we && kind == CFG_OBJ && cfg_obj == IDX_W'(k + 1)) begin
        r.valid <= cfg_valid;
        r.ext   <= cfg_ext;
        r.id    <= cfg_id;
        r.tx    <= (k == NOBJ - 1) ? 1'b0 : cfg_tx;  // last object receive-only
      end
    end
    assign objs[k] = r;
  end
endmodule

// File: rtl/can_af_match.sv
module can_af_match
  import can_af_pkg::*;
#(
  parameter  int NOBJ  = 15,
  localparam int IDX_W = $clog2(NOBJ + 1)
) (
  input  logic                  rx_ext,
  input  logic [ID_W-1:0]       rx_id,
  input  logic [STD_W-1:0]      gmask_std,
  input  logic [ID_W-1:0]       gmask_ext,
  input  logic [ID_W-1:0]       lmask_last,
  input  obj_entry_t [NOBJ-1:0] objs,
  output logic [NOBJ-1:0]       cand,
  output logic                  lo_any,
  output logic                  win_any,
  output logic [IDX_W-1:0]      win_idx
);
  logic [ID_W-1:0]  gcare;
  logic [IDX_W-1:0] lo_idx;

  assign gcare = rx_ext ? gmask_ext : {{(ID_W-STD_W){1'b0}}, gmask_std};

  for (genvar k = 0; k < NOBJ; k++) begin : g_cmp
    logic elig;
    assign elig = objs[k].valid && (objs[k].ext == rx_ext) && !objs[k].tx;
    if (k < NOBJ - 1) begin : g_low
      assign cand[k] = elig && id_match(rx_id, objs[k].id, gcare, rx_ext);
    end else begin : g_last
      assign cand[k] = elig && id_match(rx_id, objs[k].id, gcare & lmask_last, rx_ext);
    end
  end

  always_comb begin
    lo_idx = '0;
    for (int k = NOBJ - 2; k >= 0; k--) begin
      if (cand[k]) lo_idx = IDX_W'(k + 1);
    end
  end

  assign lo_any  = |cand[NOBJ-2:0];
  assign win_any = lo_any | cand[NOBJ-1];
  assign win_idx = lo_any ? lo_idx : (cand[NOBJ-1] ? IDX_W'(NOBJ) : '0);
endmodule

// File: rtl/can_af_store.sv
module can_af_store #(
  parameter  int NOBJ  = 15,
  localparam int IDX_W = $clog2(NOBJ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_en,
  input  logic [IDX_W-1:0] store_idx,
  input  logic             ack_we,
  input  logic [IDX_W-1:0] ack_idx,
  output logic             slot_sel,
  output logic             last_rd_slot,
  output logic [NOBJ-1:0]  new_data,
  output logic [NOBJ-1:0]  overrun
);
  for (genvar k = 0; k < NOBJ - 1; k++) begin : g_flag
    logic nd, ov, put, rel;
    assign put = store_en && store_idx == IDX_W'(k + 1);
    assign rel = ack_we && ack_idx == IDX_W'(k + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nd <= 1'b0;
        ov <= 1'b0;
      end else if (put) begin
        nd <= 1'b1;
        if (nd) ov <= 1'b1;
      end else if (rel) begin
        nd <= 1'b0;
        ov <= 1'b0;
      end
    end
    assign new_data[k] = nd;
    assign overrun[k]  = ov;
  end

  // Two-slot buffer of the last object.
  logic [1:0] fill;
  logic       wr_ptr, rd_ptr, ov_last;
  logic       push, pop, rel_last, full, adv;

  assign push     = store_en && store_idx == IDX_W'(NOBJ);
  assign rel_last = ack_we && ack_idx == IDX_W'(NOBJ);
  assign full     = (fill == 2'd2);
  assign pop      = rel_last && (fill != 2'd0);
  assign adv      = push && !full;
  assign slot_sel = full ? ~wr_ptr : wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill    <= 2'd0;
      wr_ptr  <= 1'b0;
      rd_ptr  <= 1'b0;
      ov_last <= 1'b0;
    end else begin
      fill <= fill + 2'(adv) - 2'(pop);
      if (adv) wr_ptr <= ~wr_ptr;
      if (pop) rd_ptr <= ~rd_ptr;
      if (push && full) ov_last <= 1'b1;
      else if (rel_last) ov_last <= 1'b0;
    end
  end

  assign new_data[NOBJ-1] = (fill != 2'd0);
  assign overrun[NOBJ-1]  = ov_last;
  assign last_rd_slot     = rd_ptr;
endmodule

// File: rtl/can_af_top.sv
module can_af_top
  import can_af_pkg::*;
#(
  parameter  int NOBJ  = 15,
  localparam int IDX_W = $clog2(NOBJ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [IDX_W-1:0] cfg_obj,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic             cfg_ext,
  input  logic             cfg_tx,
  input  logic             cfg_valid,
  input  logic             rx_valid,
  input  logic             rx_ext,
  input  logic [ID_W-1:0]  rx_id,
  input  logic             ack_we,
  input  logic [IDX_W-1:0] ack_idx,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             hit_slot,
  output logic             last_rd_slot,
  output logic [NOBJ-1:0]  new_data,
  output logic [NOBJ-1:0]  overrun
);
  logic [STD_W-1:0]      gmask_std;
  logic [ID_W-1:0]       gmask_ext, lmask_last;
  obj_entry_t [NOBJ-1:0] objs;
  logic [NOBJ-1:0]       cand;
  logic                  lo_any, win_any, store_en, slot_sel;
  logic [IDX_W-1:0]      win_idx;

  can_af_cfg #(.NOBJ(NOBJ)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_obj(cfg_obj), .cfg_id(cfg_id), .cfg_ext(cfg_ext), .cfg_tx(cfg_tx),
    .cfg_valid(cfg_valid), .gmask_std(gmask_std), .gmask_ext(gmask_ext),
    .lmask_last(lmask_last), .objs(objs)
  );

  can_af_match #(.NOBJ(NOBJ)) u_match (
    .rx_ext(rx_ext), .rx_id(rx_id), .gmask_std(gmask_std),
    .gmask_ext(gmask_ext), .lmask_last(lmask_last), .objs(objs),
    .cand(cand), .lo_any(lo_any), .win_any(win_any), .win_idx(win_idx)
  );

  assign store_en = rx_valid && win_any;

  can_af_store #(.NOBJ(NOBJ)) u_store (
    .clk(clk), .rst_n(rst_n), .store_en(store_en), .store_idx(win_idx),
    .ack_we(ack_we), .ack_idx(ack_idx), .slot_sel(slot_sel),
    .last_rd_slot(last_rd_slot), .new_data(new_data), .overrun(overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      hit_idx  <= '0;
      hit_slot <= 1'b0;
    end else begin
      hit      <= store_en;
      hit_idx  <= store_en ? win_idx : '0;
      hit_slot <= store_en && (win_idx == IDX_W'(NOBJ)) && slot_sel;
    end
  end
endmodule

// File: rtl/can_af_checker.sv
module can_af_checker #(
  parameter  int NOBJ  = 15,
  localparam int IDX_W = $clog2(NOBJ + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             hit,
  input logic [IDX_W-1:0] hit_idx,
  input logic             hit_slot,
  input logic [NOBJ-1:0]  new_data,
  input logic [NOBJ-1:0]  overrun,
  input logic             lo_any
);
  AST_HIT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(rx_valid)); // R6
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_idx != '0 && hit_idx <= IDX_W'(NOBJ))); // R6
  AST_IDX_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> hit_idx == '0); // R6
  AST_ND_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> new_data[hit_idx - 1'b1]); // R7
  AST_OVR_WITH_ND: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun & ~new_data) == '0); // R8
  AST_LAST_ONLY_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hit_idx == IDX_W'(NOBJ)) |-> !$past(lo_any)); // R4
  AST_SLOT_LAST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hit_idx != IDX_W'(NOBJ)) |-> !hit_slot); // R9

  for (genvar k = 0; k < NOBJ; k++) begin : g_ovr
    AST_OVR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun[k]) |-> ($past(new_data[k]) && $past(rx_valid))); // R8
  end
endmodule

bind can_af_top can_af_checker #(.NOBJ(NOBJ)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .hit(hit),
  .hit_idx(hit_idx), .hit_slot(hit_slot), .new_data(new_data),
  .overrun(overrun), .lo_any(lo_any)
);

// File: tb/can_af_top_test.sv
`timescale 1ns/1ps
module can_af_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [3:0]  cfg_obj = '0;
  logic [28:0] cfg_id = '0;
  logic        cfg_ext = 1'b0, cfg_tx = 1'b0, cfg_valid = 1'b0;
  logic        rx_valid = 1'b0, rx_ext = 1'b0;
  logic [28:0] rx_id = '0;
  logic        ack_we = 1'b0;
  logic [3:0]  ack_idx = '0;
  logic        hit, hit_slot, last_rd_slot;
  logic [3:0]  hit_idx;
  logic [14:0] new_data, overrun;

  can_af_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_obj(cfg_obj), .cfg_id(cfg_id), .cfg_ext(cfg_ext), .cfg_tx(cfg_tx),
    .cfg_valid(cfg_valid), .rx_valid(rx_valid), .rx_ext(rx_ext), .rx_id(rx_id),
    .ack_we(ack_we), .ack_idx(ack_idx), .hit(hit), .hit_idx(hit_idx),
    .hit_slot(hit_slot), .last_rd_slot(last_rd_slot), .new_data(new_data),
    .overrun(overrun)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // Bench model of the configuration.
  logic [28:0] m_id [1:15];
  bit          m_valid [1:15], m_ext [1:15], m_tx [1:15];
  logic [10:0] m_gstd = '1;
  logic [28:0] m_gext = '1, m_lmask = '1;
  // Bench model of the flags.
  bit e_nd [1:14], e_ov [1:14];
  int q_fill = 0, q_wr = 0, q_rd = 0;
  bit q_ov = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit care_bit(input int k, input bit ext, input int b);
    bit g = ext ? m_gext[b] : ((b < 11) ? m_gstd[b] : 1'b0);
    if (k == 15) return g && m_lmask[b];
    return g;
  endfunction

  function automatic bit obj_takes(input int k, input bit ext, input logic [28:0] id);
    int width = ext ? 29 : 11;
    if (!m_valid[k] || m_ext[k] != ext) return 0;
    if (k < 15 && m_tx[k]) return 0;
    for (int b = 0; b < width; b++)
      if (care_bit(k, ext, b) && id[b] != m_id[k][b]) return 0;
    return 1;
  endfunction

  function automatic int expect_obj(input bit ext, input logic [28:0] id);
    for (int k = 1; k <= 14; k++) if (obj_takes(k, ext, id)) return k;
    if (obj_takes(15, ext, id)) return 15;
    return 0;
  endfunction

  function automatic int exp_nd();
    int v = (q_fill != 0) ? (1 << 14) : 0;
    for (int k = 1; k <= 14; k++) if (e_nd[k]) v |= (1 << (k - 1));
    return v;
  endfunction

  function automatic int exp_ov();
    int v = q_ov ? (1 << 14) : 0;
    for (int k = 1; k <= 14; k++) if (e_ov[k]) v |= (1 << (k - 1));
    return v;
  endfunction

  task automatic cfg(input int kind, input int obj, input logic [28:0] id,
                     input bit ext, input bit tx, input bit valid);
    @(negedge clk);
    cfg_we = 1; cfg_kind = kind[1:0]; cfg_obj = obj[3:0]; cfg_id = id;
    cfg_ext = ext; cfg_tx = tx; cfg_valid = valid;
    @(negedge clk);
    cfg_we = 0;
    case (kind)
      0: m_gstd = id[10:0];
      1: m_gext = id;
      2: m_lmask = id;
      default: begin m_id[obj] = id; m_ext[obj] = ext; m_tx[obj] = tx; m_valid[obj] = valid; end
    endcase
  endtask

  // Sends one frame and checks everything it should change; returns the winner.
  task automatic frame(input bit ext, input logic [28:0] id, output int won);
    int exp = expect_obj(ext, id);
    int slot = 0;
    bit was_full = (q_fill == 2);
    @(negedge clk);
    rx_valid = 1; rx_ext = ext; rx_id = id;
    @(negedge clk);
    rx_valid = 0;
    chk((exp == 15) ? "R4" : "R3", "hit_idx", int'(hit_idx), exp);
    chk("R6", "hit", int'(hit), (exp != 0) ? 1 : 0);
    if (exp >= 1 && exp <= 14) begin
      if (e_nd[exp]) e_ov[exp] = 1;
      e_nd[exp] = 1;
    end else if (exp == 15) begin
      if (was_full) begin q_ov = 1; slot = 1 - q_wr; end
      else begin slot = q_wr; q_wr = 1 - q_wr; q_fill++; end
    end
    chk(was_full ? "R10" : "R9", "hit_slot", int'(hit_slot), slot);
    chk("R7", "new_data", int'(new_data), exp_nd());
    chk("R8", "overrun", int'(overrun), exp_ov());
    @(negedge clk);
    chk("R6", "hit pulse width", int'(hit), 0);
    won = exp;
  endtask

  task automatic release_obj(input int idx);
    @(negedge clk);
    ack_we = 1; ack_idx = idx[3:0];
    @(negedge clk);
    ack_we = 0;
    if (idx <= 14) begin
      e_nd[idx] = 0; e_ov[idx] = 0;
    end else begin
      if (q_fill > 0) begin q_fill--; q_rd = 1 - q_rd; end
      q_ov = 0;
    end
    chk("R7", "new_data after release", int'(new_data), exp_nd());
    chk("R10", "overrun after release", int'(overrun), exp_ov());
    chk("R9", "last_rd_slot", int'(last_rd_slot), q_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    int id15;
    for (int k = 1; k <= 15; k++) begin m_id[k] = '0; m_valid[k] = 0; m_ext[k] = 0; m_tx[k] = 0; end
    for (int k = 1; k <= 14; k++) begin e_nd[k] = 0; e_ov[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: reset state
    chk("R12", "hit", int'(hit), 0);
    chk("R12", "hit_idx", int'(hit_idx), 0);
    chk("R12", "new_data", int'(new_data), 0);
    chk("R12", "overrun", int'(overrun), 0);
    frame(0, 29'h0, w);
    chk("R12", "no valid object", w, 0);
    // R12: masks reset to all ones, so bit 0 is compared
    cfg(3, 1, 29'h055, 0, 0, 1);
    frame(0, 29'h054, w);
    chk("R12", "default mask exact", int'(w), 0);
    frame(0, 29'h055, w);
    chk("R11", "new object entry used", w, 1);
    release_obj(1);

    // Main configuration
    cfg(0, 0, 29'h7FC, 0, 0, 0);
    cfg(1, 0, 29'h1FFF_FF00, 0, 0, 0);
    cfg(2, 0, 29'h700, 0, 0, 0);
    for (int k = 1; k <= 14; k++) cfg(3, k, 29'(k * 132), 0, 0, 1);
    cfg(3, 4, 29'd265, 0, 0, 1);          // shares masked identifier with object 2
    cfg(3, 7, 29'(7 * 132), 0, 0, 0);     // invalid
    cfg(3, 9, 29'(9 * 132), 0, 1, 1);     // transmit
    cfg(3, 12, 29'h0ABC_D123, 1, 0, 1);   // extended
    cfg(3, 15, 29'h500, 0, 0, 1);

    // R1 R2 R3 R4: full standard identifier sweep
    for (int i = 0; i < 2048; i++) begin
      frame(0, 29'(i), w);
      if (w != 0) release_obj(w);
    end
    frame(0, 29'd265, w);
    chk("R3", "lowest of two matches", w, 2);
    if (w != 0) release_obj(w);
    frame(0, 29'(7 * 132), w);
    chk("R2", "invalid object skipped", (w == 7) ? 1 : 0, 0);
    if (w != 0) release_obj(w);
    frame(0, 29'(9 * 132), w);
    chk("R2", "transmit object skipped", (w == 9) ? 1 : 0, 0);
    if (w != 0) release_obj(w);
    frame(0, 29'h123, w);
    chk("R2", "format mismatch skipped", (w == 12) ? 1 : 0, 0);
    if (w != 0) release_obj(w);

    // R1: extended sweep under the extended mask
    for (int i = 0; i < 512; i++) begin
      frame(1, 29'h0ABC_D000 + 29'(i), w);
      if (w != 0) release_obj(w);
    end
    frame(1, 29'h0ABC_D1FF, w);
    chk("R1", "extended don't-care bits", w, 12);
    if (w != 0) release_obj(w);

    // R1: zero standard mask accepts anything at object 1
    cfg(0, 0, 29'h000, 0, 0, 0);
    frame(0, 29'h7FF, w);
    chk("R1", "all don't-care", w, 1);
    release_obj(1);
    cfg(0, 0, 29'h7FC, 0, 0, 0);

    // R5: object 15 direction written as transmit
    cfg(3, 15, 29'h500, 0, 1, 1);
    id15 = -1;
    for (int i = 0; i < 2048 && id15 < 0; i++) if (expect_obj(0, 29'(i)) == 15) id15 = i;
    frame(0, 29'(id15), w);
    chk("R5", "receive-only last object", w, 15);
    release_obj(15);

    // R8: double store into object 1
    frame(0, 29'd132, w);
    frame(0, 29'd132, w);
    chk("R8", "overrun bit 0", int'(overrun[0]), 1);
    release_obj(1);

    // R9 R10: fill both slots, then overflow
    frame(0, 29'(id15), w);
    frame(0, 29'(id15), w);
    chk("R9", "two frames no overrun", int'(overrun[14]), 0);
    frame(0, 29'(id15), w);
    chk("R10", "third frame overrun", int'(overrun[14]), 1);
    release_obj(15);
    chk("R9", "one slot still full", int'(new_data[14]), 1);
    release_obj(15);
    chk("R9", "buffer empty", int'(new_data[14]), 0);
    frame(0, 29'(id15), w);
    release_obj(15);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule